// File: doc/BRIEF.md
# Miss merging scoreboard dispatcher

This block sits behind a translation cache's miss port and in front of a bank of page table walkers. Every walker slot records the virtual page number it is resolving, so the set of busy slots doubles as a fully associative scoreboard of pages with a walk in flight. An incoming miss is compared against every busy slot at once.

A miss to a page that is already being walked is parked in that walker's private queue and starts no walk. A miss to a new page takes the lowest numbered idle walker and issues a single start pulse to the walker bank. When a walker reports its result, the block emits one translation cache fill. It then returns the first request and every parked request to the DMA side, one per cycle, each with its tag, physical frame and page size flag.

The walker slot and its scoreboard entry stay reserved until the last queued response has left. A miss that arrives while its page is still being drained is therefore absorbed, and does not start a second walk.

Top module: `miss_merge_dispatch`

## Requirements
- R1: After reset, walk_start, fill_valid and rsp_valid are low and miss_ready is high.
- R2: An accepted miss to a page with no walk in flight produces walk_start on the next cycle, with walk_vpn equal to the miss page and walk_id equal to the lowest numbered idle walker.
- R3: An accepted miss to a page with a walk in flight starts no walk, and its tag is queued on that walker.
- R4: Each walker queues at most MS+1 tags: the first request plus MS merged ones. With the queue full, miss_ready is low for a miss to that page.
- R5: With every walker busy, miss_ready is low for a miss to a page that is not in flight.
- R6: A done_valid for a walker that is walking produces, on the next cycle, one fill_valid pulse carrying the walker's page, done_pfn and done_large. A done_valid for an idle or draining walker is ignored.
- R7: Responses start the cycle after the fill and come one per cycle: first the first request's tag, then the merged tags in arrival order. Each carries the walk's frame and page size flag.
- R8: A walker and its scoreboard entry are released only on the cycle of its last response. A miss to that page accepted before then is merged and answered. A miss accepted after release starts a new walk.
- R9: When several walkers hold undrained responses, each cycle's response comes from the lowest numbered of them.
- R10: N misses to one page, with N at most MS+1, give exactly one walk_start and exactly N responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active low reset |
| miss_valid | input | 1 | A translation miss is offered |
| miss_ready | output | 1 | The offered miss is accepted this cycle |
| miss_vpn | input | VPN_W | Virtual page number of the miss |
| miss_tag | input | TAG_W | Requester tag returned with the response |
| walk_start | output | 1 | One cycle pulse: start a walk |
| walk_id | output | IW | Walker that should start |
| walk_vpn | output | VPN_W | Page that walker should resolve |
| done_valid | input | 1 | A walker reports its result |
| done_id | input | IW | Reporting walker |
| done_pfn | input | PFN_W | Physical frame found |
| done_large | input | 1 | Set when the mapping is a large page |
| fill_valid | output | 1 | One cycle pulse: write this translation into the cache |
| fill_vpn | output | VPN_W | Page of the fill |
| fill_pfn | output | PFN_W | Frame of the fill |
| fill_large | output | 1 | Page size flag of the fill |
| rsp_valid | output | 1 | A translated response is returned |
| rsp_tag | output | TAG_W | Tag of the original request |
| rsp_pfn | output | PFN_W | Translated frame |
| rsp_large | output | 1 | Page size flag |

## Verification
miss_ready is combinational and is checked in the same cycle that the miss is driven. walk_start is due one clock edge after a miss is accepted, and fill_valid one edge after done_valid. The first response is due two edges after done_valid, with the rest following on each later edge. The bench drives inputs just after a rising edge and samples outputs one nanosecond after the edge where each result is due, so every check lands on a fixed cycle. Free-running counters on the falling edge tally walk starts and responses to confirm the one-walk, N-response rule for every merge depth from 0 to MS.

// File: rtl/miss_merge_dispatch.sv
module miss_merge_dispatch #(
  parameter int NW    = 4,
  parameter int MS    = 3,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int TAG_W = 8,
  parameter int IW    = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_valid,
  output logic             miss_ready,
  input  logic [VPN_W-1:0] miss_vpn,
  input  logic [TAG_W-1:0] miss_tag,
  output logic             walk_start,
  output logic [IW-1:0]    walk_id,
  output logic [VPN_W-1:0] walk_vpn,
  input  logic             done_valid,
  input  logic [IW-1:0]    done_id,
  input  logic [PFN_W-1:0] done_pfn,
  input  logic             done_large,
  output logic             fill_valid,
  output logic [VPN_W-1:0] fill_vpn,
  output logic [PFN_W-1:0] fill_pfn,
  output logic             fill_large,
  output logic             rsp_valid,
  output logic [TAG_W-1:0] rsp_tag,
  output logic [PFN_W-1:0] rsp_pfn,
  output logic             rsp_large
);

  localparam int DEPTH = MS + 1;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int QD    = 1 << CW;

  logic [NW-1:0]    busy, drn, hit, wlarge;
  logic [VPN_W-1:0] wvpn [NW];
  logic [PFN_W-1:0] wpfn [NW];
  logic [CW-1:0]    cnt  [NW];
  logic [CW-1:0]    rd   [NW];
  logic [TAG_W-1:0] q    [NW][QD];
  logic [IW-1:0]    hit_id, free_id, dr_id;
  logic             free_any, dr_any, hit_any, room;
  logic             acc, do_alloc, do_merge, done_ok, last_pop;

  always_comb begin
    hit      = '0;
    hit_id   = '0;
    free_id  = '0;
    dr_id    = '0;
    free_any = 1'b0;
    dr_any   = 1'b0;
    for (int w = NW - 1; w >= 0; w--) begin
      hit[w] = busy[w] && (wvpn[w] == miss_vpn);
      if (hit[w]) hit_id = IW'(w);
      if (!busy[w]) begin
        free_any = 1'b1;
        free_id  = IW'(w);
      end
      if (drn[w]) begin
        dr_any = 1'b1;
        dr_id  = IW'(w);
      end
    end
  end

  assign hit_any    = |hit;
  assign room       = cnt[hit_id] < CW'(DEPTH);
  assign miss_ready = hit_any ? room : free_any;
  assign acc        = miss_valid && miss_ready;
  assign do_alloc   = acc && !hit_any;
  assign do_merge   = acc && hit_any;
  assign done_ok    = done_valid && busy[done_id] && !drn[done_id];
  assign last_pop   = dr_any && (rd[dr_id] + 1'b1 == cnt[dr_id])
                      && !(do_merge && hit_id == dr_id);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= '0;
      drn        <= '0;
      walk_start <= 1'b0;
      walk_id    <= '0;
      walk_vpn   <= '0;
      fill_valid <= 1'b0;
      fill_vpn   <= '0;
      fill_pfn   <= '0;
      fill_large <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_tag    <= '0;
      rsp_pfn    <= '0;
      rsp_large  <= 1'b0;
      for (int w = 0; w < NW; w++) begin
        cnt[w] <= '0;
        rd[w]  <= '0;
      end
    end else begin
      walk_start <= do_alloc;
      if (do_alloc) begin
        walk_id         <= free_id;
        walk_vpn        <= miss_vpn;
        busy[free_id]   <= 1'b1;
        cnt[free_id]    <= CW'(1);
        rd[free_id]     <= '0;
      end
      if (do_merge) cnt[hit_id] <= cnt[hit_id] + 1'b1;
      fill_valid <= done_ok;
      if (done_ok) begin
        fill_vpn     <= wvpn[done_id];
        fill_pfn     <= done_pfn;
        fill_large   <= done_large;
        drn[done_id] <= 1'b1;
      end
      rsp_valid <= dr_any;
      if (dr_any) begin
        rsp_tag   <= q[dr_id][rd[dr_id]];
        rsp_pfn   <= wpfn[dr_id];
        rsp_large <= wlarge[dr_id];
        rd[dr_id] <= rd[dr_id] + 1'b1;
      end
      if (last_pop) begin
        busy[dr_id] <= 1'b0;
        drn[dr_id]  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_alloc) begin
      wvpn[free_id] <= miss_vpn;
      q[free_id][0] <= miss_tag;
    end
    if (do_merge) q[hit_id][cnt[hit_id]] <= miss_tag;
    if (done_ok) begin
      wpfn[done_id]   <= done_pfn;
      wlarge[done_id] <= done_large;
    end
  end

  p_no_repeat_walk_r10: assert property (@(posedge clk) disable iff (!rst_n)
    walk_start |=> !(walk_start && walk_vpn == $past(walk_vpn)));

  p_merge_no_walk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    do_merge |=> !walk_start);

  p_fill_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |=> fill_valid && fill_pfn == $past(done_pfn));

  p_rsp_from_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(dr_any));

  for (genvar g = 0; g < NW; g++) begin : g_chk
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[g] <= CW'(DEPTH));
    p_hold_walk_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[g] && !drn[g]) |=> busy[g]);
  end

endmodule

// File: tb/miss_merge_dispatch_tb.sv
`timescale 1ns/1ps
module miss_merge_dispatch_tb_top;
  localparam int NW = 4, MS = 3, VPN_W = 20, PFN_W = 20, TAG_W = 8, IW = 2;

  logic clk = 0, rst_n = 0;
  logic miss_valid = 0, done_valid = 0, done_large = 0;
  logic [VPN_W-1:0] miss_vpn = '0;
  logic [TAG_W-1:0] miss_tag = '0;
  logic [IW-1:0] done_id = '0;
  logic [PFN_W-1:0] done_pfn = '0;
  logic miss_ready, walk_start, fill_valid, fill_large, rsp_valid, rsp_large;
  logic [IW-1:0] walk_id;
  logic [VPN_W-1:0] walk_vpn, fill_vpn;
  logic [PFN_W-1:0] fill_pfn, rsp_pfn;
  logic [TAG_W-1:0] rsp_tag;
  int total = 0, fails = 0, wcnt = 0, rcnt = 0;

  always #10 clk = ~clk;

  miss_merge_dispatch #(.NW(NW), .MS(MS), .VPN_W(VPN_W), .PFN_W(PFN_W), .TAG_W(TAG_W))
  dut_i (.clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_vpn(miss_vpn), .miss_tag(miss_tag), .walk_start(walk_start), .walk_id(walk_id),
    .walk_vpn(walk_vpn), .done_valid(done_valid), .done_id(done_id), .done_pfn(done_pfn),
    .done_large(done_large), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .fill_large(fill_large), .rsp_valid(rsp_valid),
    .rsp_tag(rsp_tag), .rsp_pfn(rsp_pfn), .rsp_large(rsp_large));

  always @(negedge clk) if (rst_n) begin
    if (walk_start) wcnt++;
    if (rsp_valid) rcnt++;
  end

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_done(input int id, input int pfn, input bit lg);
    done_valid = 1; done_id = IW'(id); done_pfn = PFN_W'(pfn); done_large = lg;
    tick;
    done_valid = 0;
  endtask

  task automatic rsp_is(input string req, input int tag);
    chk({req, " valid"}, rsp_valid, 1);
    chk({req, " tag"}, rsp_tag, tag);
  endtask

  initial begin
    #(200000 * 20);
    total++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) tick;
    rst_n = 1;
    tick;
    chk("R1 walk_start", walk_start, 0);
    chk("R1 fill_valid", fill_valid, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 miss_ready", miss_ready, 1);

    // R10 sweep over merge depth 0..MS
    for (int n = 0; n <= MS; n++) begin
      int w0, r0;
      w0 = wcnt; r0 = rcnt;
      miss_valid = 1; miss_vpn = VPN_W'('h100 + n); miss_tag = TAG_W'(16 * n);
      #1 chk("R2 ready", miss_ready, 1);
      tick;
      chk("R2 walk_start", walk_start, 1);
      chk("R2 walk_id", walk_id, 0);
      chk("R2 walk_vpn", walk_vpn, 'h100 + n);
      for (int m = 1; m <= n; m++) begin
        miss_tag = TAG_W'(16 * n + m);
        #1 chk("R3 ready", miss_ready, 1);
        tick;
        chk("R3 no walk", walk_start, 0);
      end
      if (n == MS) begin
        miss_tag = 8'hEE;
        #1 chk("R4 full stall", miss_ready, 0);
      end
      miss_valid = 0;
      send_done(0, 1000 + n, n[0]);
      chk("R6 fill_valid", fill_valid, 1);
      chk("R6 fill_vpn", fill_vpn, 'h100 + n);
      chk("R6 fill_pfn", fill_pfn, 1000 + n);
      chk("R6 fill_large", fill_large, n[0]);
      chk("R7 no early rsp", rsp_valid, 0);
      for (int m = 0; m <= n; m++) begin
        tick;
        rsp_is("R7 order", 16 * n + m);
        chk("R7 pfn", rsp_pfn, 1000 + n);
        chk("R7 large", rsp_large, n[0]);
      end
      tick;
      chk("R7 drained", rsp_valid, 0);
      chk("R10 one walk", wcnt - w0, 1);
      chk("R10 N responses", rcnt - r0, n + 1);
    end

    // R8: merge during drain, new walk after release
    miss_valid = 1; miss_vpn = 'h300; miss_tag = 8'h50;
    tick;
    chk("R8 walk", walk_start, 1);
    miss_valid = 0;
    send_done(0, 77, 0);
    miss_valid = 1; miss_tag = 8'h51;
    #1 chk("R8 merge while draining", miss_ready, 1);
    tick;
    miss_valid = 0;
    rsp_is("R8 first", 'h50);
    chk("R8 no walk", walk_start, 0);
    tick;
    rsp_is("R8 late merge", 'h51);
    tick;
    chk("R8 drained", rsp_valid, 0);
    miss_valid = 1; miss_tag = 8'h52;
    tick;
    miss_valid = 0;
    chk("R8 rewalk", walk_start, 1);
    send_done(0, 78, 0);
    tick; tick;

    // R5 / R9: fill all walkers
    for (int i = 0; i < NW; i++) begin
      miss_valid = 1; miss_vpn = VPN_W'('h200 + i); miss_tag = TAG_W'('h40 + i);
      tick;
      chk("R2 lowest idle", walk_id, i);
    end
    miss_vpn = 'h2FF;
    #1 chk("R5 all busy", miss_ready, 0);
    miss_vpn = 'h203; miss_tag = 8'h60;
    #1 chk("R3 merge ok", miss_ready, 1);
    tick;
    chk("R3 no walk", walk_start, 0);
    miss_vpn = 'h201; miss_tag = 8'h61;
    tick;
    miss_valid = 0;
    send_done(3, 3, 1);
    chk("R6 fill w3", fill_vpn, 'h203);
    send_done(1, 1, 0);
    chk("R6 fill w1", fill_vpn, 'h201);
    rsp_is("R9 w3 first", 'h43);
    tick;
    rsp_is("R9 w1 preempts", 'h41);
    tick;
    rsp_is("R9 w1 merged", 'h61);
    tick;
    rsp_is("R9 w3 resumes", 'h60);
    chk("R7 large flag", rsp_large, 1);
    tick;
    chk("R9 done", rsp_valid, 0);
    send_done(3, 9, 0);
    chk("R6 idle done ignored", fill_valid, 0);
    send_done(0, 10, 0);
    chk("R6 fill w0", fill_valid, 1);
    send_done(0, 11, 0);
    chk("R6 draining done ignored", fill_valid, 0);
    rsp_is("R7 w0", 'h40);
    chk("R6 pfn kept", rsp_pfn, 10);
    send_done(2, 12, 0);
    tick;
    rsp_is("R7 w2", 'h42);
    tick;
    chk("R1 idle again", miss_ready, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule